// File: doc/BRIEF.md
# Frequency-locked loop tuner controller

This block steers the tune word of a digitally controlled oscillator. The goal is an oscillator edge count per reference period that matches a programmed target. A single fast clock samples everything. The reference period is marked by a one-cycle strobe. The oscillator arrives as a square wave sampled in the same domain, and the block counts its rising edges between strobes. At each strobe it compares that count with the target and updates the tune word.

Lock can be acquired in two ways. The fast way is a successive-approximation search that takes one tune bit per reference period, most significant bit first. The slow way walks the tune word by one step per period, starting from zero. After acquisition the block tracks the target one step at a time. It raises a lock flag when the count is within one step of the target. It can also toggle the low tune bit each period, so the average frequency lands between two steps.

The oscillator is divided by a power of two and then gated to form the output clock. The output is gated off while the block is disabled, or, in request-gated mode, while no peripheral request is present. It can also be masked for the duration of the search.

Top module: `fll_ctrl`

## Requirements
- R1: With `bsearch_i` high, the first reference strobe after the block starts running loads tune 0x80. Each of the next 8 strobes handles one bit, from bit 7 down to bit 0. At each of these strobes the current trial bit is cleared if the measured count exceeds the target, and the next lower bit is set as the new trial. The lock flag can rise at the 8th strobe and not earlier.
- R2: With `bsearch_i` low, the start strobe loads tune 0. Each later strobe moves the tune word by exactly one step toward the target. It saturates at 0 and 255.
- R3: At every evaluation strobe, `lock_o` becomes 1 if |count − target| ≤ 1 and 0 otherwise. Between strobes it does not change. It reads 0 after reset.
- R4: While `dith_en_i` is high and the block was already locked, bit 0 of `tune_o` inverts at each strobe, and the base value is held while the error stays within one step. With dithering off, a zero error leaves `tune_o` unchanged.
- R5: While the search runs and `mask_srch_i` is high, `clk_o` stays low. With the mask low, the output keeps toggling during the search. Once the search ends, the output resumes.
- R6: `div_sel_i` codes 0 to 5 divide the oscillator by 2^code. With an oscillator period of 2 clock cycles, each high phase of `clk_o` lasts 2^code cycles.
- R7: The division code resets to 5 (divide by 32). Codes 6 and 7 are ignored, and the last valid division stays in force.
- R8: A new division takes effect only at the end of a divided output period, so no high phase shorter than both the old and the new width appears.
- R9: The block runs when `en_i` is high and either `req_gated_i` is low or at least one `req_i` bit is high. While it is not running, `clk_o` and `lock_o` are low and the tune word is held. When it runs again, acquisition restarts from the start strobe.
- R10: The count used at a strobe is the number of oscillator rising edges since the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| req_gated_i | input | 1 | Run only while a request is present |
| req_i | input | NREQ | Peripheral clock requests |
| bsearch_i | input | 1 | Acquire by bitwise search instead of walking |
| mask_srch_i | input | 1 | Hold output low during the search |
| dith_en_i | input | 1 | Toggle tune LSB each period once locked |
| div_sel_i | input | DIV_W | Output division code |
| target_i | input | TUNE_W | Target edge count per reference period |
| ref_tick_i | input | 1 | One-cycle reference period strobe |
| dco_i | input | 1 | Sampled oscillator waveform |
| tune_o | output | TUNE_W | Oscillator tune word |
| lock_o | output | 1 | Count within one step of target |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
Loss of the last peripheral request can land on the same cycle as a reference strobe that would otherwise evaluate a count. The bench forces this by dropping the request on the strobe cycle of a locked loop. The strobe must then be discarded: lock clears on the next cycle, the tune word is held, and the next strobe after the request returns must reload 0x80. A second overlap is a division change that arrives while a divided period is still running. The bench changes the code at random points in the output waveform and accepts only the old width or the new width for every high phase.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRCH = 2'd1,
    ST_TRK  = 2'd2
  } fll_st_e;
endpackage

// File: rtl/fll_meas.sv
module fll_meas #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dco_i,
  input  logic             tick_i,
  output logic             dco_q_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] meas_o
);
  logic [CNT_W-1:0] acc_q;

  assign rise_o = dco_i & ~dco_q_o;
  // count including an edge landing on the strobe cycle
  assign meas_o = (&acc_q) ? acc_q : acc_q + CNT_W'(rise_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dco_q_o <= 1'b0;
      acc_q   <= '0;
    end else begin
      dco_q_o <= dco_i;
      if (tick_i)                acc_q <= '0;
      else if (rise_o && !(&acc_q)) acc_q <= acc_q + 1'b1;
    end
  end
endmodule

// File: rtl/fll_tuner.sv
module fll_tuner
  import fll_pkg::*;
#(
  parameter int TUNE_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              bsearch_i,
  input  logic              dither_i,
  input  logic [TUNE_W-1:0] target_i,
  input  logic [CNT_W-1:0]  meas_i,
  output logic [TUNE_W-1:0] tune_o,
  output logic [TUNE_W-1:0] base_o,
  output logic              lock_o,
  output logic              srch_o,
  output logic              trk_o
);
  localparam int IDX_W = $clog2(TUNE_W);
  localparam logic [TUNE_W-1:0] MID = {1'b1, {(TUNE_W-1){1'b0}}};
  localparam logic [TUNE_W-1:0] TOP = '1;

  fll_st_e           st_q;
  logic [TUNE_W-1:0] base_q, srch_nxt;
  logic [IDX_W-1:0]  idx_q;
  logic              lock_q, dith_q;
  logic [CNT_W:0]    meas_x, tgt_x, diff;
  logic              gt, lt, near, hold;

  assign meas_x = {1'b0, meas_i};
  assign tgt_x  = {{(CNT_W+1-TUNE_W){1'b0}}, target_i};
  assign diff   = meas_x - tgt_x;
  assign gt     = meas_x > tgt_x;
  assign lt     = meas_x < tgt_x;
  assign near   = (diff == '0) || (diff == (CNT_W+1)'(1)) || (diff == '1);
  assign hold   = lock_q && dither_i && near;

  always_comb begin
    srch_nxt = base_q;
    if (gt) srch_nxt[idx_q] = 1'b0;
    if (idx_q != '0) srch_nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      lock_q <= 1'b0;
      dith_q <= 1'b0;
    end else if (!run_i) begin
      st_q   <= ST_IDLE;
      lock_q <= 1'b0;
      dith_q <= 1'b0;
    end else if (tick_i) begin
      case (st_q)
        ST_IDLE: begin
          lock_q <= 1'b0;
          dith_q <= 1'b0;
          if (bsearch_i) begin
            base_q <= MID;
            idx_q  <= IDX_W'(TUNE_W-1);
            st_q   <= ST_SRCH;
          end else begin
            base_q <= '0;
            st_q   <= ST_TRK;
          end
        end
        ST_SRCH: begin
          base_q <= srch_nxt;
          if (idx_q == '0) begin
            st_q   <= ST_TRK;
            lock_q <= near;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        ST_TRK: begin
          lock_q <= near;
          dith_q <= (lock_q && dither_i) ? ~dith_q : 1'b0;
          if (!hold) begin
            if (gt && base_q != '0)      base_q <= base_q - 1'b1;
            else if (lt && base_q != TOP) base_q <= base_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tune_o = base_q ^ {{(TUNE_W-1){1'b0}}, dith_q};
  assign base_o = base_q;
  assign lock_o = lock_q;
  assign srch_o = (st_q == ST_SRCH);
  assign trk_o  = (st_q == ST_TRK);
endmodule

// File: rtl/fll_clkdiv.sv
module fll_clkdiv #(
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 5,
  parameter int RST_DIV = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dco_q_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             gate_i,
  output logic             clk_o,
  output logic [DIV_W-1:0] act_o,
  output logic [DIV_W-1:0] pend_o
);
  localparam int CTR_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [DIV_W-1:0] act_q, pend_q;
  logic [CTR_W-1:0] ctr_q;
  logic             bound, div_out;

  // end of a divided period: next rise would wrap the counter
  assign bound = rise_i &&
                 ((act_q == '0) || (ctr_q == CTR_W'((32'd1 << act_q) - 32'd1)));

  always_comb begin
    div_out = dco_q_i;
    for (int k = 1; k <= DIV_MAX; k++) begin
      if (act_q == DIV_W'(k)) div_out = ctr_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= DIV_W'(RST_DIV);
      pend_q <= DIV_W'(RST_DIV);
      ctr_q  <= '0;
      clk_o  <= 1'b0;
    end else begin
      if (div_sel_i <= DIV_W'(DIV_MAX)) pend_q <= div_sel_i;
      if (bound) begin
        act_q <= pend_q;
        ctr_q <= '0;
      end else if (rise_i) begin
        ctr_q <= ctr_q + 1'b1;
      end
      clk_o <= gate_i & div_out;
    end
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl #(
  parameter int TUNE_W  = 8,
  parameter int CNT_W   = 12,
  parameter int NREQ    = 4,
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 5,
  parameter int RST_DIV = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_gated_i,
  input  logic [NREQ-1:0]   req_i,
  input  logic              bsearch_i,
  input  logic              mask_srch_i,
  input  logic              dith_en_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [TUNE_W-1:0] target_i,
  input  logic              ref_tick_i,
  input  logic              dco_i,
  output logic [TUNE_W-1:0] tune_o,
  output logic              lock_o,
  output logic              clk_o
);
  logic              run_w, gate_w, dco_q_w, rise_w, srch_w, trk_w;
  logic [CNT_W-1:0]  meas_w;
  logic [TUNE_W-1:0] base_w;
  logic [DIV_W-1:0]  div_act_w, div_pend_w;

  assign run_w  = en_i & (~req_gated_i | (|req_i));
  assign gate_w = run_w & ~(mask_srch_i & srch_w);

  fll_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dco_i   (dco_i),
    .tick_i  (ref_tick_i),
    .dco_q_o (dco_q_w),
    .rise_o  (rise_w),
    .meas_o  (meas_w)
  );

  fll_tuner #(.TUNE_W(TUNE_W), .CNT_W(CNT_W)) u_tuner (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .tick_i    (ref_tick_i),
    .bsearch_i (bsearch_i),
    .dither_i  (dith_en_i),
    .target_i  (target_i),
    .meas_i    (meas_w),
    .tune_o    (tune_o),
    .base_o    (base_w),
    .lock_o    (lock_o),
    .srch_o    (srch_w),
    .trk_o     (trk_w)
  );

  fll_clkdiv #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .RST_DIV(RST_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dco_q_i   (dco_q_w),
    .rise_i    (rise_w),
    .div_sel_i (div_sel_i),
    .gate_i    (gate_w),
    .clk_o     (clk_o),
    .act_o     (div_act_w),
    .pend_o    (div_pend_w)
  );
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk #(
  parameter int TUNE_W  = 8,
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_tick_i,
  input logic              mask_srch_i,
  input logic [DIV_W-1:0]  div_sel_i,
  input logic              run_i,
  input logic              srch_i,
  input logic              trk_i,
  input logic [TUNE_W-1:0] base_i,
  input logic              lock_i,
  input logic              clk_out_i,
  input logic              rise_i,
  input logic [DIV_W-1:0]  act_i,
  input logic [DIV_W-1:0]  pend_i
);
  localparam int CW = $clog2(TUNE_W) + 2;
  logic [CW-1:0] srch_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                srch_ticks <= '0;
    else if (!srch_i)           srch_ticks <= '0;
    else if (ref_tick_i)        srch_ticks <= srch_ticks + 1'b1;
  end

  AST_SEARCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_ticks <= CW'(TUNE_W)); // R1
  AST_WALK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_i && $past(trk_i)) |-> ((base_i == $past(base_i)) ||
      (base_i == $past(base_i) + 1'b1) || (base_i == $past(base_i) - 1'b1))); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_tick_i && run_i) |=> $stable(lock_i)); // R3
  AST_SAFE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_i && mask_srch_i) |=> !clk_out_i); // R5
  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i > DIV_W'(DIV_MAX)) |=> $stable(pend_i)); // R7
  AST_DIV_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(act_i)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!lock_i && !clk_out_i)); // R9
endmodule

bind fll_ctrl fll_ctrl_chk #(.TUNE_W(TUNE_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_tick_i  (ref_tick_i),
  .mask_srch_i (mask_srch_i),
  .div_sel_i   (div_sel_i),
  .run_i       (run_w),
  .srch_i      (srch_w),
  .trk_i       (trk_w),
  .base_i      (base_w),
  .lock_i      (lock_o),
  .clk_out_i   (clk_o),
  .rise_i      (rise_w),
  .act_i       (div_act_w),
  .pend_i      (div_pend_w)
);

// File: tb/fll_ctrl_tb.sv
module fll_ctrl_tb;
  localparam int TW = 8;
  localparam int NREQ = 4;
  localparam int P = 520;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, en_i, req_gated_i, bsearch_i, mask_srch_i, dith_en_i;
  logic [NREQ-1:0] req_i;
  logic [2:0] div_sel_i;
  logic [TW-1:0] target_i, tune_o;
  logic ref_tick_i, dco_i, lock_o, clk_o;

  fll_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .req_gated_i(req_gated_i),
    .req_i(req_i), .bsearch_i(bsearch_i), .mask_srch_i(mask_srch_i),
    .dith_en_i(dith_en_i), .div_sel_i(div_sel_i), .target_i(target_i),
    .ref_tick_i(ref_tick_i), .dco_i(dco_i), .tune_o(tune_o),
    .lock_o(lock_o), .clk_o(clk_o)
  );

  int n_chk = 0, n_err = 0, hi_cnt = 0, n_lat = 0;
  bit steady = 1'b0, drop_req = 1'b0;
  logic [TW-1:0] smp_tune;
  logic smp_lock;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_search(input int t);
    int v = 0;
    for (int b = TW-1; b >= 0; b--) begin
      if (!((v | (1 << b)) > t)) v = v | (1 << b);
    end
    return v;
  endfunction

  function automatic int exp_walk_lock(input int t);
    return (t > 1) ? t : 1;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_o) hi_cnt++;
      ref_tick_i = 1'b0;
      dco_i = steady ? ~dco_i : 1'b0;
    end
  endtask

  // oscillator model: edges per period equal the tune word latched after the strobe
  task automatic run_period();
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      if (clk_o) hi_cnt++;
      if (c == 1) begin
        smp_tune = tune_o;
        smp_lock = lock_o;
        n_lat = int'(tune_o);
      end
      if (c == 0 && drop_req) req_i = '0;
      ref_tick_i = (c == 0);
      dco_i = (c >= 1) && (c <= 2*n_lat - 1) && (c % 2 == 1);
    end
  endtask

  task automatic meas_hi(input int npulse, input int a, input int b, input string rq);
    int got = 0, w = 0;
    bit in_p = 1'b0, seen_low = 1'b0;
    while (got < npulse) begin
      @(negedge clk);
      if (clk_o) begin
        if (seen_low) begin in_p = 1'b1; w++; end
      end else begin
        seen_low = 1'b1;
        if (in_p) begin
          check(w == a || w == b, rq, w, b);
          got++;
          in_p = 1'b0;
          w = 0;
        end
      end
      ref_tick_i = 1'b0;
      dco_i = ~dco_i;
    end
  endtask

  task automatic restart();
    steady = 1'b0;
    req_gated_i = 1'b0;
    en_i = 1'b0;
    cycles(3);
    en_i = 1'b1;
  endtask

  task automatic bin_run(input int t, input bit d, input bit s);
    bsearch_i = 1'b1; target_i = TW'(t); dith_en_i = d; mask_srch_i = s; div_sel_i = 3'd0;
    restart();
    run_period();
    check(smp_tune == 8'h80, "R1 start", smp_tune, 8'h80);
    check(!smp_lock, "R3 start", smp_lock, 0);
    hi_cnt = 0;
    for (int j = 1; j <= 7; j++) begin
      run_period();
      check(!smp_lock, "R1 early lock", smp_lock, 0);
    end
    if (s) check(hi_cnt == 0, "R5 masked", hi_cnt, 0);
    else   check(hi_cnt > 0, "R5 unmasked", hi_cnt, 1);
    hi_cnt = 0;
    run_period();
    check(smp_lock, "R1 lock at 8", smp_lock, 1);
    check(smp_tune == TW'(exp_search(t)), "R1 result", smp_tune, exp_search(t));
    check(hi_cnt > 0, "R5 release", hi_cnt, 1);
    run_period();
    check(smp_tune == (d ? TW'(t ^ 1) : TW'(t)), "R4 dither 1", smp_tune, d ? (t ^ 1) : t);
    run_period();
    check(smp_tune == TW'(t), "R4 dither 2", smp_tune, t);
    check(smp_lock, "R3 held", smp_lock, 1);
  endtask

  task automatic walk_run(input int t);
    int kl = exp_walk_lock(t);
    bsearch_i = 1'b0; target_i = TW'(t); dith_en_i = 1'b0; mask_srch_i = 1'b0;
    restart();
    run_period();
    check(smp_tune == '0, "R2 start", smp_tune, 0);
    for (int k = 1; k <= kl; k++) begin
      run_period();
      if (k < kl) begin
        check(!smp_lock, "R3 walk unlocked", smp_lock, 0);
        check(smp_tune == TW'(k), "R2 step", smp_tune, k);
      end
    end
    check(smp_lock, "R3 walk lock", smp_lock, 1);
    check(smp_tune == TW'(t), "R10 exact count", smp_tune, t);
    if (t >= 5) begin
      target_i = TW'(t - 5);
      for (int j = 1; j <= 5; j++) begin
        run_period();
        check(smp_tune == TW'(t - j), "R2 down step", smp_tune, t - j);
        check(smp_lock == (j == 5), "R3 relock", smp_lock, (j == 5));
      end
    end
  endtask

  initial begin
    int old_k, nk, tr;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; en_i = 1'b0; req_gated_i = 1'b0; req_i = '0; bsearch_i = 1'b0;
    mask_srch_i = 1'b0; dith_en_i = 1'b0; div_sel_i = 3'd7; target_i = '0;
    ref_tick_i = 1'b0; dco_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(tune_o == '0, "R3 reset tune", tune_o, 0);
    check(!lock_o, "R3 reset lock", lock_o, 0);
    check(!clk_o, "R9 reset clk", clk_o, 0);

    // divider: reset code kept under reserved input
    en_i = 1'b1; steady = 1'b1;
    cycles(40);
    meas_hi(3, 32, 32, "R7 reset div");
    div_sel_i = 3'd2; cycles(80);
    meas_hi(3, 4, 4, "R6 div4");
    div_sel_i = 3'd6; cycles(80);
    meas_hi(3, 4, 4, "R7 reserved");
    div_sel_i = 3'd0; cycles(20);
    meas_hi(3, 1, 1, "R6 div1");
    old_k = 0;
    for (int i = 0; i < 6; i++) begin
      nk = 1 + int'($urandom % 5);
      cycles(int'($urandom % 40));
      div_sel_i = 3'(nk);
      meas_hi(4, 1 << old_k, 1 << nk, "R8 switch");
      cycles(70);
      meas_hi(2, 1 << nk, 1 << nk, "R6 settled");
      old_k = nk;
    end

    // request gating on a free-running oscillator
    req_gated_i = 1'b1; req_i = '0; cycles(4);
    hi_cnt = 0; cycles(100);
    check(hi_cnt == 0, "R9 no request", hi_cnt, 0);
    req_i = 4'b0100; cycles(4);
    hi_cnt = 0; cycles(100);
    check(hi_cnt > 0, "R9 request", hi_cnt, 1);
    req_gated_i = 1'b0; req_i = '0; en_i = 1'b0; cycles(4);
    hi_cnt = 0; cycles(100);
    check(hi_cnt == 0, "R9 disabled", hi_cnt, 0);
    steady = 1'b0;

    // search: directed then random
    bin_run(200, 1'b0, 1'b1);
    bin_run(77, 1'b1, 1'b0);
    bin_run(255, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tr = 4 + int'($urandom % 252);
      bin_run(tr, 1'(($urandom >> 3) & 1), 1'(($urandom >> 5) & 1));
    end

    // walk
    walk_run(37);
    walk_run(0);

    // request drop on the strobe cycle of a locked loop
    bsearch_i = 1'b1; target_i = 8'd150; dith_en_i = 1'b0; mask_srch_i = 1'b0;
    restart();
    req_gated_i = 1'b1; req_i = 4'b0010;
    for (int j = 0; j < 9; j++) run_period();
    check(smp_lock, "R9 pre-drop lock", smp_lock, 1);
    drop_req = 1'b1;
    run_period();
    drop_req = 1'b0;
    check(!smp_lock, "R9 drop lock", smp_lock, 0);
    check(smp_tune == 8'd150, "R9 tune held", smp_tune, 150);
    req_i = 4'b1000;
    run_period();
    check(smp_tune == 8'h80, "R9 restart", smp_tune, 8'h80);
    for (int j = 0; j < 8; j++) run_period();
    check(smp_lock && smp_tune == 8'd150, "R9 relock", smp_tune, 150);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule